// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block drives and samples sixteen general-purpose pins on behalf of a processor. Software reaches it through a small word-addressed register bus. Through that bus it sets which pins drive, what they drive, and which pin transitions raise an interrupt. Each pin's output latch can be changed as a whole, or through atomic set and clear masks, which avoids a read-modify-write sequence.

Incoming pin levels pass through a two-stage synchronizer. The block then compares the synchronized value with its value one cycle earlier to find rising and falling edges. A transition that is enabled for its pin and direction sets that pin's pending flag, and a single interrupt line stays high while any flag is set. Software clears the flags by writing ones. A per-pin external mode bit hands the pin's output value to a peripheral signal in place of the latch.

Reads are combinational from the address currently on the bus. Writes take effect at the rising clock edge when both the enable and write strobes are high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0, `pinOe` is 0 (all pins are inputs) and `irq` is low.
- R2: Offset 0 is the direction register and can be read back. A 1 in bit n drives `pinOe[n]` high (output), a 0 makes the pin an input. `pinOe` follows the write from the next cycle.
- R3: Offset 1 loads the output latch and reads back the latch value, not the pin level. When `altMode[n]` is 0, `pinOut[n]` equals latch bit n.
- R4: A write to the direction register never changes the output latch. Example: writing 0xFFFF to the latch and then 0xFFFF to direction drives all pins high.
- R5: A write to offset 6 sets the latch bits at the 1 positions of the data. A write to offset 7 clears them. Bits written as 0 are unchanged. Both offsets read as 0.
- R6: Offset 2 returns the `pinIn` value that was present two rising edges earlier (two-flop synchronizer). Writes to offset 2 have no effect.
- R7: Offset 4 holds the rising-edge enables. A low-to-high transition of a synchronized pin whose enable bit is 1 sets that pin's pending bit. The bit is visible on the third rising edge after the change at `pinIn`.
- R8: Offset 3 holds the falling-edge enables. A high-to-low transition of a synchronized pin whose enable bit is 1 sets that pin's pending bit, with the same latency as R7. Transitions on pins whose enable is 0 set nothing.
- R9: Offset 5 reads the pending bits. Writing 1 to a bit clears it, and writing 0 leaves it. If an edge sets a bit in the same cycle that a write clears it, the bit stays set.
- R10: `irq` is high exactly when at least one pending bit is set.
- R11: When `altMode[n]` is 1, `pinOut[n]` equals `altOut[n]`, whatever the latch holds.
- R12: Offsets 8 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Bus access strobe |
| busWe | input | 1 | Write when high, read when low |
| busAddr | input | 4 | Word offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the current offset |
| pinIn | input | 16 | Pin levels seen at the pads |
| pinOut | output | 16 | Output value per pin |
| pinOe | output | 16 | Output enable per pin |
| altMode | input | 16 | Per-pin source select for the output value |
| altOut | input | 16 | Peripheral output value per pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench places a write-one clear on a pending bit in the same cycle that an edge sets it. A design that gave the clear priority would lose that interrupt.

It writes the latch while the pins are inputs and then turns them to outputs. A design that reset the latch whenever a pin became an input would drive zeros at that point.

Edge checks are timed to the exact synchronizer depth. A missing or extra stage would set the pending bit a cycle off, and the input-data readback would show the wrong value.

Writes of zeros to the mask and pending offsets, and writes to the unused offsets, are checked to leave every register unchanged. An off-by-one decode, or a mask applied to the wrong operand, would corrupt the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFF_W = 4;

  typedef enum logic [3:0] {
    OFF_DIR   = 4'd0,
    OFF_LATCH = 4'd1,
    OFF_LEVEL = 4'd2,
    OFF_FALL  = 4'd3,
    OFF_RISE  = 4'd4,
    OFF_PEND  = 4'd5,
    OFF_SETM  = 4'd6,
    OFF_CLRM  = 4'd7
  } regOff_t;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_DIR, SEL_LATCH, SEL_LEVEL, SEL_FALL, SEL_RISE, SEL_PEND
  } readSel_t;

  typedef struct packed {
    logic dirWr;
    logic latchWr;
    logic fallWr;
    logic riseWr;
    logic pendWr;
    logic setWr;
    logic clrWr;
  } gpioStrobes_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned AW = OFF_W
) (
  input  logic          busEn,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  output gpioStrobes_t  strobes,
  output readSel_t      readSel
);
  localparam int unsigned MAPPED = 8;

  logic inMap;
  logic doWr;

  assign inMap = (busAddr < AW'(MAPPED));
  assign doWr  = busEn && busWe && inMap;

  always_comb begin
    strobes = '0;
    if (doWr) begin
      unique case (busAddr[2:0])
        OFF_DIR[2:0]:   strobes.dirWr   = 1'b1;
        OFF_LATCH[2:0]: strobes.latchWr = 1'b1;
        OFF_FALL[2:0]:  strobes.fallWr  = 1'b1;
        OFF_RISE[2:0]:  strobes.riseWr  = 1'b1;
        OFF_PEND[2:0]:  strobes.pendWr  = 1'b1;
        OFF_SETM[2:0]:  strobes.setWr   = 1'b1;
        OFF_CLRM[2:0]:  strobes.clrWr   = 1'b1;
        default:        strobes         = '0;
      endcase
    end
  end

  always_comb begin
    readSel = SEL_ZERO;
    if (inMap) begin
      unique case (busAddr[2:0])
        OFF_DIR[2:0]:   readSel = SEL_DIR;
        OFF_LATCH[2:0]: readSel = SEL_LATCH;
        OFF_LEVEL[2:0]: readSel = SEL_LEVEL;
        OFF_FALL[2:0]:  readSel = SEL_FALL;
        OFF_RISE[2:0]:  readSel = SEL_RISE;
        OFF_PEND[2:0]:  readSel = SEL_PEND;
        default:        readSel = SEL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS   = 16,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrobes_t     strobes,
  input  readSel_t         readSel,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] altMode,
  input  logic [NPINS-1:0] altOut,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic [NPINS-1:0] latchQ,
  output logic             irq
);
  logic [NPINS-1:0] dirQ, fallEnQ, riseEnQ, pendQ, prevQ, levelQ;
  logic [NPINS-1:0] syncQ [SYNC_ST];
  logic [NPINS-1:0] riseHit, fallHit, pendNext;

  // input synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_ST; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign levelQ = syncQ[SYNC_ST-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= levelQ;
  end

  assign riseHit  = levelQ & ~prevQ & riseEnQ;
  assign fallHit  = ~levelQ & prevQ & fallEnQ;
  // an edge arriving together with a clear keeps the bit set
  assign pendNext = (strobes.pendWr ? (pendQ & ~wdata) : pendQ) | riseHit | fallHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ    <= '0;
      latchQ  <= '0;
      fallEnQ <= '0;
      riseEnQ <= '0;
      pendQ   <= '0;
    end else begin
      pendQ <= pendNext;
      if (strobes.dirWr)   dirQ    <= wdata;
      if (strobes.fallWr)  fallEnQ <= wdata;
      if (strobes.riseWr)  riseEnQ <= wdata;
      if (strobes.latchWr) latchQ  <= wdata;
      else if (strobes.setWr) latchQ <= latchQ | wdata;
      else if (strobes.clrWr) latchQ <= latchQ & ~wdata;
    end
  end

  // per-pin output source selection
  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      assign pinOut[p] = altMode[p] ? altOut[p] : latchQ[p];
    end
  endgenerate

  assign pinOe = dirQ;
  assign irq   = |pendQ;

  always_comb begin
    unique case (readSel)
      SEL_DIR:   rdata = dirQ;
      SEL_LATCH: rdata = latchQ;
      SEL_LEVEL: rdata = levelQ;
      SEL_FALL:  rdata = fallEnQ;
      SEL_RISE:  rdata = riseEnQ;
      SEL_PEND:  rdata = pendQ;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned AW    = OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busEn,
  input  logic             busWe,
  input  logic [AW-1:0]    busAddr,
  input  logic [NPINS-1:0] busWdata,
  output logic [NPINS-1:0] busRdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  input  logic [NPINS-1:0] altMode,
  input  logic [NPINS-1:0] altOut,
  output logic             irq
);
  gpioStrobes_t     strobes;
  readSel_t         readSel;
  logic [NPINS-1:0] latchQ;

  gpio_ctrl #(.AW(AW)) u_ctrl (
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .strobes(strobes), .readSel(readSel)
  );

  gpio_datapath #(.NPINS(NPINS), .SYNC_ST(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .readSel(readSel),
    .wdata(busWdata), .pinIn(pinIn), .altMode(altMode), .altOut(altOut),
    .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe), .latchQ(latchQ), .irq(irq)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned AW    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busEn,
  input logic             busWe,
  input logic [AW-1:0]    busAddr,
  input logic [NPINS-1:0] busWdata,
  input logic [NPINS-1:0] pinOe,
  input logic [NPINS-1:0] latchQ
);
  logic wrAny;
  assign wrAny = busEn && busWe;

  assert_dir_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == AW'(0)) |=> (pinOe == $past(busWdata)));

  assert_latch_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == AW'(0)) |=> (latchQ == $past(latchQ)));

  assert_set_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == AW'(6)) |=> (latchQ == ($past(latchQ) | $past(busWdata))));

  assert_clr_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == AW'(7)) |=> (latchQ == ($past(latchQ) & ~$past(busWdata))));

  assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr >= AW'(8)) |=> ($stable(latchQ) && $stable(pinOe)));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .pinOe(pinOe), .latchQ(latchQ)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic [15:0] pinIn = '0, pinOut, pinOe;
  logic [15:0] altMode = '0, altOut = '0;
  logic        irq;

  int nChecks = 0, nFails = 0;
  logic done = 1'b0;
  logic [15:0] mDir = 0, mLat = 0, mFall = 0, mRise = 0, mPend = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .altMode(altMode), .altOut(altOut), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expOut();
    return (altMode & altOut) | (~altMode & mLat);
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busEn = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 0; busWe = 0;
    case (a)
      4'd0: mDir = d;
      4'd1: mLat = d;
      4'd3: mFall = d;
      4'd4: mRise = d;
      4'd5: mPend = mPend & ~d;
      4'd6: mLat = mLat | d;
      4'd7: mLat = mLat & ~d;
      default: ;
    endcase
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busEn = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    busEn = 0;
  endtask

  // change pins at a negedge and let three rising edges pass
  task automatic drivePins(input logic [15:0] v);
    logic [15:0] old;
    @(negedge clk);
    old = pinIn;
    pinIn = v;
    repeat (3) @(negedge clk);
    mPend = mPend | (v & ~old & mRise) | (~v & old & mFall);
  endtask

  task automatic checkAll(input string tag);
    logic [15:0] r;
    busRead(4'd0, r); chk({tag, " R2 dir"}, r, mDir);
    busRead(4'd1, r); chk({tag, " R3 latch"}, r, mLat);
    busRead(4'd2, r); chk({tag, " R6 level"}, r, pinIn);
    busRead(4'd3, r); chk({tag, " R8 fallEn"}, r, mFall);
    busRead(4'd4, r); chk({tag, " R7 riseEn"}, r, mRise);
    busRead(4'd5, r); chk({tag, " R9 pend"}, r, mPend);
    busRead(4'd6, r); chk({tag, " R5 set reads 0"}, r, 16'h0);
    busRead(4'd7, r); chk({tag, " R5 clr reads 0"}, r, 16'h0);
    #1;
    chk({tag, " R2 pinOe"}, pinOe, mDir);
    chk({tag, " R3/R11 pinOut"}, pinOut, expOut());
    chk({tag, " R10 irq"}, {15'h0, irq}, {15'h0, |mPend});
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      busRead(a[3:0], r);
      chk("R1 reset read", r, 16'h0);
    end
    #1;
    chk("R1 pinOe", pinOe, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R4 latch retained across direction change
    busWrite(4'd1, 16'hFFFF);
    busWrite(4'd0, 16'hFFFF);
    #1 chk("R4 all high", pinOut, 16'hFFFF);
    busWrite(4'd0, 16'h0000);
    busWrite(4'd0, 16'hFFFF);
    #1 chk("R4 latch survives input", pinOut, 16'hFFFF);

    // R5 zero mask no effect, partial masks
    busWrite(4'd7, 16'h0000);
    checkAll("R5 zero clr");
    busWrite(4'd7, 16'h00F0);
    busWrite(4'd6, 16'h0000);
    checkAll("R5 masks");

    // R6 synchronizer depth
    @(negedge clk); pinIn = 16'hA5A5;
    @(negedge clk);
    busEn = 1; busWe = 0; busAddr = 4'd2;
    #1 chk("R6 level not yet", busRdata, 16'h0000);
    @(negedge clk);
    #1 chk("R6 level after two edges", busRdata, 16'hA5A5);
    busEn = 0;
    busWrite(4'd2, 16'h1234);
    checkAll("R6 write ignored");

    // R7 rising edge pending latency
    busWrite(4'd4, 16'h0002);
    @(negedge clk); pinIn = 16'hA5A7;
    @(negedge clk); @(negedge clk);
    #1 chk("R7 not before third edge", {15'h0, irq}, 16'h0);
    @(negedge clk);
    #1 chk("R7 irq third edge", {15'h0, irq}, 16'h1);
    mPend = 16'h0002;
    checkAll("R7 pend");

    // R9 write zero keeps, write one clears
    busWrite(4'd5, 16'h0000);
    checkAll("R9 zero write");
    busWrite(4'd5, 16'h0002);
    checkAll("R9 cleared");

    // R8 falling edge, R9 edge wins over simultaneous clear
    busWrite(4'd3, 16'h0001);
    busWrite(4'd5, 16'h0000);
    @(negedge clk); pinIn = 16'hA5A6;
    @(negedge clk); @(negedge clk);
    busEn = 1; busWe = 1; busAddr = 4'd5; busWdata = 16'h0001;
    @(negedge clk); busEn = 0; busWe = 0;
    mPend = 16'h0001;
    checkAll("R8/R9 edge wins");
    busWrite(4'd5, 16'h0001);
    checkAll("R9 clear after");

    // R8 disabled edge sets nothing
    drivePins(16'h0000);
    checkAll("R8 disabled pins");

    // R12 unmapped writes ignored
    for (int a = 8; a < 16; a++) busWrite(a[3:0], 16'hFFFF);
    checkAll("R12 unmapped");
    for (int a = 8; a < 16; a++) begin
      busRead(a[3:0], r);
      chk("R12 unmapped read", r, 16'h0);
    end

    // R11 peripheral output select
    altMode = 16'hFF00; altOut = 16'h0F0F;
    checkAll("R11 alt");

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 6) busWrite(4'($urandom_range(0, 7)), 16'($urandom));
      else if (op < 8) drivePins(16'($urandom));
      else if (op == 8) busWrite(4'($urandom_range(8, 15)), 16'($urandom));
      else begin
        altMode = 16'($urandom); altOut = 16'($urandom);
      end
      if (i % 5 == 0) checkAll("rand");
    end
    checkAll("final");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    done = 1;
    $finish;
  end
endmodule